// File: doc/BRIEF.md
# Push-Button Accelerating Up/Down Trimmer

This block replaces a mechanical trimmer with two push buttons. Each button input is active low and idles high. A level on either input is accepted as a press only after it has stayed low for a fixed filter time. An accepted press moves an 8-bit position code one step: the raise button moves it up and the lower button moves it down. The code feeds a DAC, which lies outside this block.

If the button stays down, the position keeps stepping. For the first second of the hold it steps at a slow pace. After that it steps at a fast pace until the button is let go. The code clamps at its two ends and never wraps.

All times are counted in millisecond ticks, which are divided down from the clock. Because the divide ratio is a parameter, a simulation can run with short times. A synchronous load port sets the code to a value recalled from elsewhere. An inhibit input stops all stepping while it is high.

Top module: `pb_trim_ctrl`

## Requirements
- R1: After a synchronous reset, `pos_o` equals `RESET_CODE`, which defaults to 0x00.
- R2: A low level on `up_n_i` or `dn_n_i` counts as a press only after it has been seen low on `DB_MS` consecutive ms ticks. A low pulse shorter than `DB_MS-1` tick periods leaves `pos_o` unchanged.
- R3: When a press is accepted, `pos_o` changes by exactly one step. `up_n_i` adds 1 and `dn_n_i` subtracts 1. Outside of a load, `pos_o` never changes by more than 1 in one cycle.
- R4: While a press is held, a further step occurs every `SLOW_MS` ticks, counted from the accepted press, for the first `HOLD_MS` ticks of the hold.
- R5: From `HOLD_MS` ticks into the hold, steps occur every `FAST_MS` ticks until release.
- R6: Releasing the button returns the block to standby. The next press starts again with the slow pace.
- R7: `pos_o` saturates. An up step at 0xFF leaves 0xFF, and a down step at 0x00 leaves 0x00.
- R8: While both inputs are low, neither one steps, and the two never step in the same cycle. When one input is released, the other must pass the full filter time again before it steps.
- R9: When `load_i` is high at a clock edge, `pos_o` takes `load_val_i` after that edge. Load wins over any step in that cycle.
- R10: While `inhibit_i` is high, `pos_o` does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_n_i | input | 1 | Raise button, active low, asynchronous |
| dn_n_i | input | 1 | Lower button, active low, asynchronous |
| load_i | input | 1 | Load strobe for a recalled code |
| load_val_i | input | W | Code to load |
| inhibit_i | input | 1 | Blocks stepping while high |
| pos_o | output | W | Registered position code for the DAC |

## Verification
Some properties are checked by assertions on every cycle:
- the code moves by at most one step, and never wraps at either end;
- a load is taken exactly on the next cycle;
- inhibit freezes the code;
- the two directions never step together;
- a blocked pair of buttons drops any accepted press;
- a press is accepted only on a tick.

Other properties only the bench scenarios can show, because they compare step counts with elapsed hold time:
- the filter length;
- the slow and fast repeat spacing and the change from one to the other;
- the return to slow pacing after a release;
- re-filtering of the button that is still held after a double press.

// File: rtl/pb_trim_pkg.sv
package pb_trim_pkg;
  typedef enum int {
    KEY_UP = 0,
    KEY_DN = 1
  } key_idx_e;

  localparam int NUM_KEYS = 2;

  function automatic int bits_for(input int max_val);
    return (max_val > 1) ? $clog2(max_val + 1) : 1;
  endfunction
endpackage

// File: rtl/pb_tick_gen.sv
module pb_tick_gen #(
  parameter int CLK_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int TW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [TW-1:0] LAST = TW'(CLK_PER_MS - 1);

  logic [TW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (div_q == LAST);
      div_q  <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/pb_key_filter.sv
module pb_key_filter #(
  parameter int DB_MS = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic key_n_i,
  input  logic block_i,
  output logic low_o,
  output logic held_o
);
  localparam int CW = pb_trim_pkg::bits_for(DB_MS);
  localparam logic [CW-1:0] DONE = CW'(DB_MS - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], key_n_i};
  end

  assign low_o = ~sync_q[1];

  always_ff @(posedge clk) begin
    if (rst || !low_o || block_i) begin
      cnt_q  <= '0;
      held_o <= 1'b0;
    end else if (tick_i && !held_o) begin
      if (cnt_q == DONE) begin
        held_o <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R8
  blocked_drop_chk: assert property (@(posedge clk) disable iff (rst)
    block_i |=> !held_o);

  // R2
  accept_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(held_o) |-> $past(tick_i) && $past(low_o));
endmodule

// File: rtl/pb_repeat_sched.sv
module pb_repeat_sched #(
  parameter int SLOW_MS = 250,
  parameter int HOLD_MS = 1000,
  parameter int FAST_MS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic held_i,
  output logic step_o
);
  localparam int HW = pb_trim_pkg::bits_for(HOLD_MS);
  localparam int RMAX = (SLOW_MS > FAST_MS) ? SLOW_MS : FAST_MS;
  localparam int RW = pb_trim_pkg::bits_for(RMAX);

  logic          held_q;
  logic [HW-1:0] hold_q;
  logic [RW-1:0] rep_q;
  logic [RW-1:0] limit;
  logic [RW-1:0] rep_nxt;
  logic          rep_due;
  logic          fresh;

  assign limit   = (hold_q < HW'(HOLD_MS)) ? RW'(SLOW_MS) : RW'(FAST_MS);
  assign rep_nxt = rep_q + 1'b1;
  assign rep_due = rep_nxt >= limit;
  assign fresh   = held_i && !held_q;
  assign step_o  = fresh || (held_i && held_q && tick_i && rep_due);

  always_ff @(posedge clk) begin
    if (rst || !held_i) begin
      held_q <= 1'b0;
      hold_q <= '0;
      rep_q  <= '0;
    end else begin
      held_q <= 1'b1;
      if (fresh) begin
        hold_q <= '0;
        rep_q  <= '0;
      end else if (tick_i) begin
        if (hold_q < HW'(HOLD_MS)) hold_q <= hold_q + 1'b1;
        rep_q <= rep_due ? '0 : rep_nxt;
      end
    end
  end

  // R6
  standby_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !held_i |=> (hold_q == '0) && (rep_q == '0));
endmodule

// File: rtl/pb_pos_counter.sv
module pb_pos_counter #(
  parameter int W = 8,
  parameter logic [W-1:0] RESET_CODE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inhibit_i,
  output logic [W-1:0] pos_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o <= RESET_CODE;
    end else if (load_i) begin
      pos_o <= load_val_i;
    end else if (!inhibit_i) begin
      if (inc_i && !dec_i && pos_o != TOP)
        pos_o <= pos_o + 1'b1;
      else if (dec_i && !inc_i && pos_o != '0)
        pos_o <= pos_o - 1'b1;
    end
  end

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (pos_o == $past(pos_o)) || (pos_o == $past(pos_o) + W'(1))
                || (pos_o == $past(pos_o) - W'(1)));

  // R7
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && pos_o == TOP) |=> pos_o != '0);

  // R7
  no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && pos_o == '0) |=> pos_o != TOP);

  // R9
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> pos_o == $past(load_val_i));

  // R10
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inhibit_i && !load_i) |=> $stable(pos_o));
endmodule

// File: rtl/pb_trim_ctrl.sv
module pb_trim_ctrl #(
  parameter int W          = 8,
  parameter int CLK_PER_MS = 50000,
  parameter int DB_MS      = 30,
  parameter int SLOW_MS    = 250,
  parameter int HOLD_MS    = 1000,
  parameter int FAST_MS    = 50,
  parameter logic [W-1:0] RESET_CODE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_n_i,
  input  logic         dn_n_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inhibit_i,
  output logic [W-1:0] pos_o
);
  import pb_trim_pkg::*;

  logic                tick;
  logic [NUM_KEYS-1:0] key_n;
  logic [NUM_KEYS-1:0] key_low;
  logic [NUM_KEYS-1:0] key_held;
  logic [NUM_KEYS-1:0] key_step;
  logic                both_low;

  assign key_n[KEY_UP] = up_n_i;
  assign key_n[KEY_DN] = dn_n_i;
  assign both_low      = &key_low;

  pb_tick_gen #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    pb_key_filter #(.DB_MS(DB_MS)) u_filt (
      .clk(clk), .rst(rst), .tick_i(tick), .key_n_i(key_n[g]),
      .block_i(both_low), .low_o(key_low[g]), .held_o(key_held[g])
    );
    pb_repeat_sched #(.SLOW_MS(SLOW_MS), .HOLD_MS(HOLD_MS), .FAST_MS(FAST_MS)) u_sched (
      .clk(clk), .rst(rst), .tick_i(tick), .held_i(key_held[g]),
      .step_o(key_step[g])
    );
  end

  pb_pos_counter #(.W(W), .RESET_CODE(RESET_CODE)) u_pos (
    .clk(clk), .rst(rst), .inc_i(key_step[KEY_UP]), .dec_i(key_step[KEY_DN]),
    .load_i(load_i), .load_val_i(load_val_i), .inhibit_i(inhibit_i),
    .pos_o(pos_o)
  );

  // R8
  single_dir_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(key_step));
endmodule

// File: tb/pb_trim_ctrl_tb.sv
module pb_trim_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T   = 16;
  localparam int DB  = 6;
  localparam int SLW = 12;
  localparam int HLD = 48;
  localparam int FST = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up_n = 1'b1, dn_n = 1'b1, load = 1'b0, inhibit = 1'b0;
  logic [7:0] load_val = '0;
  logic [7:0] pos;

  int checks = 0, fails = 0;
  bit done = 0;
  int ref_pos;

  always #(CLK_PERIOD/2) clk = ~clk;

  pb_trim_ctrl #(.W(8), .CLK_PER_MS(T), .DB_MS(DB), .SLOW_MS(SLW),
                 .HOLD_MS(HLD), .FAST_MS(FST), .RESET_CODE(8'h00)) u_dut (
    .clk(clk), .rst(rst), .up_n_i(up_n), .dn_n_i(dn_n), .load_i(load),
    .load_val_i(load_val), .inhibit_i(inhibit), .pos_o(pos)
  );

  function automatic int steps_for(input int x);
    if (x < HLD) return 1 + x / SLW;
    return HLD / SLW + 1 + (x - HLD) / FST;
  endfunction

  function automatic bit near_step(input int x);
    if (x < HLD) return (x % SLW) == SLW - 1;
    return (x % FST) == FST - 1;
  endfunction

  function automatic int sat_move(input int start, input bit up, input int n);
    int r;
    r = up ? start + n : start - n;
    if (r > 255) r = 255;
    if (r < 0) r = 0;
    return r;
  endfunction

  task automatic check(input string req, input int exp_v);
    @(negedge clk);
    checks++;
    if (int'(pos) != exp_v) begin
      fails++;
      $display("FAIL %s: pos=0x%02h expected 0x%02h", req, pos, exp_v[7:0]);
    end
  endtask

  task automatic edge_drive();
    @(posedge clk); #1;
  endtask

  task automatic hold_for(input bit up, input int x);
    edge_drive();
    if (up) up_n = 1'b0; else dn_n = 1'b0;
    repeat ((DB + x) * T + 8) @(posedge clk);
    #1;
    up_n = 1'b1; dn_n = 1'b1;
    repeat (40) @(posedge clk);
  endtask

  task automatic do_load(input int v);
    edge_drive();
    load = 1'b1; load_val = v[7:0];
    edge_drive();
    load = 1'b0;
    ref_pos = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    ref_pos = 0;
    check("R1 reset code", 0);

    // R2: short glitch ignored
    edge_drive(); up_n = 1'b0;
    repeat ((DB - 2) * T) @(posedge clk);
    #1 up_n = 1'b1;
    repeat (40) @(posedge clk);
    check("R2 short pulse", 0);

    // R3: single steps
    hold_for(1'b1, 0); check("R3 up single", 1);
    hold_for(1'b0, 0); check("R3 down single", 0);
    hold_for(1'b0, 0); check("R7 floor", 0);

    // R4 slow, R5 fast
    hold_for(1'b1, 30); check("R4 slow repeat", 3);
    hold_for(1'b1, 60); check("R5 fast repeat", 11);

    // R6 restart slow after release
    hold_for(1'b1, 5); hold_for(1'b1, 5); check("R6 two short presses", 13);
    hold_for(1'b1, 13); check("R6 slow after release", 15);

    // R9 load, R7 ceiling
    edge_drive(); load = 1'b1; load_val = 8'hFE;
    @(negedge clk); @(negedge clk); checks++;
    if (pos != 8'hFE) begin
      fails++; $display("FAIL R9 load: pos=0x%02h expected 0xfe", pos);
    end
    #1 load = 1'b0;
    hold_for(1'b1, 60); check("R7 ceiling", 255);
    do_load(3);
    hold_for(1'b0, 60); check("R7 floor after fast", 0);

    // R10 inhibit
    do_load(8'h40);
    inhibit = 1'b1;
    hold_for(1'b1, 30); check("R10 inhibit", 8'h40);
    inhibit = 1'b0;

    // R8 both pressed
    edge_drive(); up_n = 1'b0; dn_n = 1'b0;
    repeat ((DB + 30) * T) @(posedge clk);
    check("R8 both pressed", 8'h40);
    edge_drive(); dn_n = 1'b1;
    repeat ((DB + 13) * T + 8) @(posedge clk);
    #1 up_n = 1'b1;
    repeat (40) @(posedge clk);
    check("R8 remaining key re-filtered", 8'h42);
    ref_pos = 8'h42;

    // random presses
    for (int i = 0; i < 30; i++) begin
      int x;
      bit up;
      if ($urandom_range(0, 3) == 0) do_load(int'($urandom_range(0, 255)));
      up = 1'($urandom_range(0, 1));
      x = int'($urandom_range(0, 75));
      while (near_step(x)) x++;
      hold_for(up, x);
      ref_pos = sat_move(ref_pos, up, steps_for(x));
      check(x < HLD ? "R4 random hold" : "R5 random hold", ref_pos);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule